// File: doc/BRIEF.md
# Rate 2/3 (1,7) Run-Length-Limited Write Encoder

This block turns a stream of 2-bit NRZ symbols into a serial (1,7) run-length-limited code stream for a disk write path. Each accepted symbol becomes a three-bit code group, shifted out most significant bit first. One bit leaves on each code-rate enable, so the code clock runs at 1.5 times the NRZ bit rate. A five-state machine picks the group from the current state and the symbol, and it also picks the next state. The machine starts in state 0. When the gate opens and the symbol stays at 00, it emits the repeating 010 pattern, which is the 3T preamble. No separate preamble generator is needed.

The write gate frames each write. While the gate is low the output is held at zero and the state machine is cleared. Opening and closing the gate need no synchronization. Symbols arrive with a valid strobe on the enable that starts a group. That enable comes directly after the last bit of the previous group. A test bypass sends the raw least significant input bit straight to the output, with no coding.

Top module: `rll17_encoder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `code_out` becomes 0 and the encoder state returns to 0.
- R2: A symbol is accepted only on a `code_en` cycle at a group boundary with `sym_valid` high. Its three code bits appear on `code_out` after that enable and the next two enables, most significant bit first.
- R3: In states 0, 1 and 2 the group is 010, 000 and 100 respectively. The next state for symbol values 0, 1, 2 and 3 (symbol = {MSB, LSB}) is 0, 2, 4 and 3.
- R4: In state 3, symbol values 0, 1 and 2 give group 101 with next states 0, 1 and 4, and value 3 gives 100 with next state 1. In state 4, symbol values 0, 1 and 2 give 001 with next states 0, 1 and 4, and value 3 gives 010 with next state 1.
- R5: Every write that begins after the gate was low starts encoding from state 0.
- R6: While `wr_gate` is low, `code_out` is 0 at the next edge and any partly sent group is dropped.
- R7: With the gate high and every symbol 00 from state 0, the output repeats 010 (3T preamble) until a non-zero symbol arrives.
- R8: With symbols supplied without gaps, the encoded stream never has two adjacent ones and never has more than seven zeros in a row.
- R9: With `bypass` high and the gate high, each `code_en` copies `sym_in[0]` to `code_out`, and the encoder state and group position are cleared.
- R10: In a gated, non-bypass cycle without `code_en`, `code_out` and the group position do not change.
- R11: A `code_en` at a group boundary without `sym_valid` emits a 0 and leaves the encoder state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_gate | input | 1 | Write gate; low inhibits writing and clears the encoder |
| code_en | input | 1 | Code-rate enable, one pulse per code bit |
| sym_valid | input | 1 | Symbol strobe, valid on the enable that starts a group |
| sym_in | input | 2 | NRZ symbol, bit 1 = MSB, bit 0 = LSB |
| bypass | input | 1 | Uncoded test mode: LSB passed to output |
| code_out | output | 1 | Serial (1,7) code bit |

## Verification
The embedded properties assume that the source raises `sym_valid` only on an enable at a group boundary. They also assume that the run-length checks hold only while symbols arrive without underrun. For that reason the run-length tracker restarts on an underrun enable, on bypass and while the gate is low. The bench derives `sym_valid` from its own model of the group position, so it only strobes a symbol when its expected queue of code bits is empty. It introduces underruns only in a dedicated phase. The `code_en` pattern is randomized so that holding between enables is exercised without ever breaking the framing.

// File: rtl/rll17_pkg.sv
// Shared types and constants for the (1,7) write encoder.
// Assumes a 2-bit symbol and a 3-bit code group (rate 2/3).
package rll17_pkg;
    localparam int SYM_W   = 2;
    localparam int GRP_W   = 3;
    localparam int N_ST    = 5;
    localparam int ST_W    = $clog2(N_ST);
    localparam int K_MAX   = 7;

    typedef enum logic [ST_W-1:0] {
        ST0 = 3'd0,
        ST1 = 3'd1,
        ST2 = 3'd2,
        ST3 = 3'd3,
        ST4 = 3'd4
    } enc_st_t;

    typedef struct packed {
        logic [GRP_W-1:0] grp;
        enc_st_t          nxt;
    } enc_step_t;
endpackage

// File: rtl/rll17_code_table.sv
// Combinational code table: maps (state, symbol) to a code group and next state.
// Assumes the state input is one of the five legal states.
module rll17_code_table
    import rll17_pkg::*;
(
    input  enc_st_t          cur_st,
    input  logic [SYM_W-1:0] sym,
    output enc_step_t        step
);
    enc_st_t nxt_low;

    // Next state shared by states 0..2: depends on the symbol only.
    always_comb begin
        case (sym)
            2'd0:    nxt_low = ST0;
            2'd1:    nxt_low = ST2;
            2'd2:    nxt_low = ST4;
            default: nxt_low = ST3;
        endcase
    end

    // Group and next-state selection per current state.
    always_comb begin
        step.grp = '0;
        step.nxt = ST0;
        case (cur_st)
            ST0: begin step.grp = 3'b010; step.nxt = nxt_low; end
            ST1: begin step.grp = 3'b000; step.nxt = nxt_low; end
            ST2: begin step.grp = 3'b100; step.nxt = nxt_low; end
            ST3, ST4: begin
                if (sym == 2'd3) begin
                    step.grp = (cur_st == ST3) ? 3'b100 : 3'b010;
                    step.nxt = ST1;
                end else begin
                    step.grp = (cur_st == ST3) ? 3'b101 : 3'b001;
                    case (sym)
                        2'd0:    step.nxt = ST0;
                        2'd1:    step.nxt = ST1;
                        default: step.nxt = ST4;
                    endcase
                end
            end
            default: begin step.grp = '0; step.nxt = ST0; end
        endcase
    end
endmodule

// File: rtl/rll17_state_reg.sv
// Encoder state register. Advances on each accepted symbol; cleared by a
// closed gate or bypass. Assumes a synchronous active-low reset.
module rll17_state_reg
    import rll17_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clear,
    input  logic    advance,
    input  enc_st_t nxt_st,
    output enc_st_t cur_st
);
    // Hold, clear or advance the encoder state.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cur_st <= ST0;
        else if (advance)    cur_st <= nxt_st;
    end

    p_state_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cur_st inside {ST0, ST1, ST2, ST3, ST4});
    p_clear_to_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> cur_st == ST0);
endmodule

// File: rtl/rll17_serializer.sv
// Group shifter: loads a code group at a group boundary and sends it MSB
// first, one bit per enable; in bypass it forwards a raw bit instead.
// Assumes load is only raised on an enable at a boundary.
module rll17_serializer
    import rll17_pkg::*;
#(
    parameter int GW = GRP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate,
    input  logic          en,
    input  logic          bypass,
    input  logic          load,
    input  logic [GW-1:0] grp,
    input  logic          raw_bit,
    output logic          bit_out,
    output logic          at_boundary
);
    localparam int CW = (GW > 1) ? $clog2(GW) : 1;
    localparam logic [CW-1:0] LAST = CW'(GW - 1);

    logic [CW-1:0] pos;
    logic [GW-1:0] shreg;

    assign at_boundary = (pos == '0);

    // Bit position, shift register and output bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !gate) begin
            pos     <= '0;
            shreg   <= '0;
            bit_out <= 1'b0;
        end else if (bypass) begin
            pos   <= '0;
            shreg <= '0;
            if (en) bit_out <= raw_bit;
        end else if (en) begin
            if (at_boundary) begin
                if (load) begin
                    bit_out <= grp[GW-1];
                    shreg   <= grp << 1;
                    pos     <= CW'(1);
                end else begin
                    bit_out <= 1'b0;
                end
            end else begin
                bit_out <= shreg[GW-1];
                shreg   <= shreg << 1;
                pos     <= (pos == LAST) ? '0 : pos + CW'(1);
            end
        end
    end

    p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST);
    p_gate_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> !bit_out && at_boundary);
    p_bypass_lsb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gate && bypass && en |=> bit_out == $past(raw_bit));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gate && !bypass && !en |=> $stable(bit_out) && $stable(pos));
endmodule

// File: rtl/rll17_encoder.sv
// Top of the rate 2/3 (1,7) write encoder. Ties the code table, state
// register and group shifter together and tracks run lengths for checking.
// Assumes sym_valid is raised only on an enable at a group boundary.
module rll17_encoder
    import rll17_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_gate,
    input  logic             code_en,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_in,
    input  logic             bypass,
    output logic             code_out
);
    localparam int ZW = $clog2(K_MAX + 2) + 1;

    enc_st_t   cur_st;
    enc_step_t step;
    logic      at_boundary;
    logic      load;
    logic      clear_st;

    assign load     = wr_gate && code_en && !bypass && at_boundary && sym_valid;
    assign clear_st = !wr_gate || bypass;

    rll17_code_table u_table (
        .cur_st (cur_st),
        .sym    (sym_in),
        .step   (step)
    );

    rll17_state_reg u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear_st),
        .advance (load),
        .nxt_st  (step.nxt),
        .cur_st  (cur_st)
    );

    rll17_serializer #(.GW(GRP_W)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate        (wr_gate),
        .en          (code_en),
        .bypass      (bypass),
        .load        (load),
        .grp         (step.grp),
        .raw_bit     (sym_in[0]),
        .bit_out     (code_out),
        .at_boundary (at_boundary)
    );

    // Run-length tracking of the encoded stream, used only by the checks below.
    logic          bit_evt;
    logic          bit_evt_d;
    logic          underrun;
    logic          last_one;
    logic [ZW-1:0] zrun;

    assign bit_evt  = wr_gate && code_en && !bypass && (!at_boundary || sym_valid);
    assign underrun = wr_gate && code_en && !bypass && at_boundary && !sym_valid;

    // Record the last emitted encoded bit and the current zero run.
    always_ff @(posedge clk) begin
        if (!rst_n || !wr_gate || bypass || underrun) begin
            bit_evt_d <= 1'b0;
            last_one  <= 1'b0;
            zrun      <= '0;
        end else begin
            bit_evt_d <= bit_evt;
            if (bit_evt_d) begin
                last_one <= code_out;
                zrun     <= code_out ? '0 : ((zrun == '1) ? zrun : zrun + ZW'(1));
            end
        end
    end

    p_no_adjacent_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_evt_d && wr_gate && !bypass |-> !(last_one && code_out));
    p_zero_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_evt_d && wr_gate && !bypass |-> code_out || (zrun < ZW'(K_MAX)));
    p_sym_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_gate && code_en && sym_valid && !bypass |-> at_boundary);
endmodule

// File: tb/tb_rll17_encoder.sv
// Self-checking bench: behavioural model with a queue of pending code bits,
// compared against code_out after every clock edge.
module tb_rll17_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_gate = 1'b0;
    logic       code_en = 1'b0;
    logic       sym_valid = 1'b0;
    logic [1:0] sym_in = 2'd0;
    logic       bypass = 1'b0;
    logic       code_out;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    // model state
    int  m_st = 0;
    bit  m_q[$];
    bit  m_exp = 1'b0;
    bit  m_last = 1'b0;
    int  m_zrun = 0;
    bit  m_track = 1'b0;

    rll17_encoder dut (
        .clk(clk), .rst_n(rst_n), .wr_gate(wr_gate), .code_en(code_en),
        .sym_valid(sym_valid), .sym_in(sym_in), .bypass(bypass), .code_out(code_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Table from R3 and R4.
    function automatic void enc_ref(input int st, input int s, output int grp, output int nxt);
        int low_nxt[4] = '{0, 2, 4, 3};
        int hi_nxt[3]  = '{0, 1, 4};
        case (st)
            0: begin grp = 3'b010; nxt = low_nxt[s]; end
            1: begin grp = 3'b000; nxt = low_nxt[s]; end
            2: begin grp = 3'b100; nxt = low_nxt[s]; end
            3: begin grp = (s == 3) ? 3'b100 : 3'b101; nxt = (s == 3) ? 1 : hi_nxt[s]; end
            default: begin grp = (s == 3) ? 3'b010 : 3'b001; nxt = (s == 3) ? 1 : hi_nxt[s]; end
        endcase
    endfunction

    task automatic check(input bit cond, input string req, input int act, input int exp_v);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp_v, $time);
        end
    endtask

    // One clock: apply inputs, advance the model, compare after the edge.
    task automatic tick(input bit g, input bit e, input bit v, input bit byp,
                        input logic [1:0] s, input string req);
        int grp, nxt;
        bit b;
        wr_gate = g; code_en = e; sym_valid = v; bypass = byp; sym_in = s;
        @(posedge clk);
        #1;
        if (!rst_n || !g) begin
            m_st = 0; m_q.delete(); m_exp = 0; m_track = 0; m_last = 0; m_zrun = 0;
        end else if (byp) begin
            m_st = 0; m_q.delete(); m_track = 0; m_last = 0; m_zrun = 0;
            if (e) m_exp = s[0];
        end else if (e) begin
            if (m_q.size() == 0) begin
                if (v) begin
                    enc_ref(m_st, int'(s), grp, nxt);
                    for (int i = 2; i >= 0; i--) m_q.push_back(grp[i]);
                    m_st = nxt;
                end else begin
                    m_track = 0; m_last = 0; m_zrun = 0;   // R11 underrun
                    m_q.push_back(1'b0);
                end
            end
            b = m_q.pop_front();
            m_exp = b;
            if (v || m_track || m_q.size() != 0 || b) begin
                if (m_track) begin
                    check(!(m_last && b), "R8 adjacent ones", int'(b), 0);
                    m_zrun = b ? 0 : m_zrun + 1;
                    check(m_zrun <= 7, "R8 zero run", m_zrun, 7);
                end else begin
                    m_zrun = b ? 0 : 1;
                end
                m_last = b;
                m_track = 1;
            end
        end
        check(code_out === m_exp, req, int'(code_out), int'(m_exp));
    endtask

    // Send one symbol as three enabled bit times.
    task automatic send(input logic [1:0] s, input string req);
        tick(1, 1, 1, 0, s, req);
        tick(1, 1, 0, 0, 2'd0, req);
        tick(1, 1, 0, 0, 2'd0, req);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst_n = 0;
        repeat (3) tick(1, 1, 1, 0, 2'd3, "R1 reset output");
        rst_n = 1;
        tick(0, 0, 0, 0, 2'd0, "R6 gate low idle");

        // R7: preamble from all-zero symbols, then first non-zero symbol
        for (int i = 0; i < 6; i++) send(2'd0, "R7 preamble 010");
        send(2'd2, "R7 preamble end");
        send(2'd0, "R4 state4 after preamble");

        // R3/R4: every (state, symbol) pair reached from a fresh gate (R5)
        for (int st = 0; st < 5; st++) begin
            for (int s = 0; s < 4; s++) begin
                tick(0, 1, 0, 0, 2'd0, "R6 gate drop");
                case (st)
                    1: begin send(2'd3, "R5 path"); send(2'd3, "R5 path"); end
                    2: send(2'd1, "R5 path");
                    3: send(2'd3, "R5 path");
                    4: send(2'd2, "R5 path");
                    default: ;
                endcase
                send(2'(s), (st < 3) ? "R3 table" : "R4 table");
                send(2'd0, "R3 next state");
            end
        end

        // R6: drop gate in the middle of a group, R5: restart in state 0
        send(2'd3, "R6 prefill");
        tick(1, 1, 1, 0, 2'd1, "R6 mid group");
        tick(1, 1, 0, 0, 2'd0, "R6 mid group");
        for (int i = 0; i < 3; i++) tick(0, i != 1, 0, 0, 2'd3, "R6 gate low zero");
        send(2'd0, "R5 restart group 010");

        // R10: enables with gaps, output holds
        for (int i = 0; i < 4; i++) begin
            tick(1, 1, 1, 0, 2'(i), "R10 load");
            tick(1, 0, 0, 0, 2'd3, "R10 hold");
            tick(1, 1, 0, 0, 2'd0, "R10 bit2");
            tick(1, 0, 1, 0, 2'd2, "R10 hold strobe ignored");
            tick(1, 1, 0, 0, 2'd0, "R10 bit3");
        end

        // R11: underrun emits zero, state kept
        send(2'd3, "R11 prefill");
        tick(1, 1, 0, 0, 2'd0, "R11 underrun zero");
        tick(1, 1, 0, 0, 2'd0, "R11 underrun zero");
        send(2'd3, "R11 state kept");
        send(2'd1, "R11 state kept");

        // R9: bypass passes LSB, then encoding resumes in state 0
        send(2'd2, "R9 prefill");
        for (int i = 0; i < 12; i++) tick(1, (i % 3) != 2, 0, 1, 2'($urandom_range(0, 3)), "R9 bypass lsb");
        send(2'd0, "R9 resume state0");

        // R2/R8: random symbols with a random enable pattern, continuous supply
        for (int i = 0; i < 30000; i++) begin
            bit e;
            e = ($urandom_range(0, 3) != 0);
            tick(1, e, e && (m_q.size() == 0), 0, 2'($urandom_range(0, 3)), "R2 random stream");
        end

        // R1: reset mid-stream
        rst_n = 0;
        tick(1, 1, 1, 0, 2'd1, "R1 reset mid stream");
        rst_n = 1;
        send(2'd0, "R1 after reset state0");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule